// File: doc/BRIEF.md
# Block-Boundary Two-Input Stream Selector

This block forwards one of two framed streams to a single output. Input 0 carries user traffic and input 1 carries traffic from a test-pattern generator. Each input presents valid, start-of-packet, end-of-packet and data, and receives a ready and an xon back. The output presents the same framing fields and receives ready and xon from downstream.

A one-bit select input names the wanted source. A low select means the generator is off, so the user stream flows by default. A change of select is applied only when no packet is open on the current source. A packet is therefore never cut, and the output never starts in the middle of a frame. The source that is not selected sees xon and ready held low, which pauses it at block level instead of dropping its data. No FIFO sits in the path. Data, framing, ready and xon all pass through combinationally, and only the current source and the open-packet flag are stored.

Top module: `blk_stream_sel`

## Requirements
- R1: While reset is asserted and after its release, the current source is the user input (index 0) and no packet is open, whatever the select input shows.
- R2: For the current source, out_valid_o is its valid gated by the frame rule of R6, and out_sop_o, out_eop_o and out_data_o mirror its fields combinationally. Its ready_o equals out_ready_i and its xon_o equals out_xon_i.
- R3: When no packet is open and none opens in the current cycle, the current source becomes the select value (0 = user, 1 = generator) from the next clock cycle on.
- R4: While a packet is open on the current source, select changes are ignored. The source switches at the earliest in the cycle after the accepted end-of-packet beat.
- R5: The source that is not current has ready_o = 0 and xon_o = 0, and its valid, framing and data have no effect on the outputs.
- R6: When no packet is open, a valid beat without start-of-packet on the current source is discarded: out_valid_o stays 0 and that source's ready_o is 1.
- R7: A beat carrying both start-of-packet and end-of-packet leaves no packet open, so a select change given in that cycle takes effect in the next cycle.
- R8: A beat counts as accepted only when out_ready_i is 1. An end-of-packet beat held with out_ready_i = 0 does not close the packet.
- R9: A select pulse that starts and ends inside an open packet leaves the current source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Wanted source: 0 user, 1 generator |
| usr_valid_i | input | 1 | User beat valid |
| usr_sop_i | input | 1 | User start of packet |
| usr_eop_i | input | 1 | User end of packet |
| usr_data_i | input | DATA_W | User data |
| usr_ready_o | output | 1 | Ready to user source |
| usr_xon_o | output | 1 | Block-level xon to user source |
| gen_valid_i | input | 1 | Generator beat valid |
| gen_sop_i | input | 1 | Generator start of packet |
| gen_eop_i | input | 1 | Generator end of packet |
| gen_data_i | input | DATA_W | Generator data |
| gen_ready_o | output | 1 | Ready to generator |
| gen_xon_o | output | 1 | Block-level xon to generator |
| out_valid_o | output | 1 | Output beat valid |
| out_sop_o | output | 1 | Output start of packet |
| out_eop_o | output | 1 | Output end of packet |
| out_data_o | output | DATA_W | Output data |
| out_ready_i | input | 1 | Downstream ready |
| out_xon_i | input | 1 | Downstream block-level xon |

## Verification
The bench targets a select change that arrives mid-packet and is withdrawn again before the end. A design that samples select every cycle would splice the other source into the open frame. It also holds an end-of-packet beat with ready low. A design that closes frames on valid alone would switch one beat early and lose the real last beat. Single-beat packets check that a frame opening and closing in the same cycle does not stall a switch. Idle non-start beats check that a freshly selected source caught mid-frame is flushed rather than forwarded. A pseudo-random sweep of all field combinations compares every output each cycle against an arithmetic model built from the requirements.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic {
    SRC_USR = 1'b0,
    SRC_GEN = 1'b1
  } src_e;
endpackage

// File: rtl/bss_frame_track.sv
module bss_frame_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic ready_i,
  output logic pass_o,
  output logic open_o,
  output logic open_nxt_o
);
  logic open_q;
  logic acc;

  assign pass_o = valid_i & (open_q | sop_i);
  assign acc    = pass_o & ready_i;

  always_comb begin
    open_nxt_o = open_q;
    if (acc && eop_i)      open_nxt_o = 1'b0;
    else if (acc && sop_i) open_nxt_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= open_nxt_o;
  end

  assign open_o = open_q;

  // R8
  eop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && open_q && eop_i && !ready_i) |=> open_o);

  // R7
  single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i && eop_i && ready_i) |=> !open_o);
endmodule

// File: rtl/bss_src_ctl.sv
module bss_src_ctl
  import bss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic open_nxt_i,
  output src_e cur_o
);
  src_e cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cur_q <= SRC_USR;
    else if (!open_nxt_i) cur_q <= src_e'(sel_i);
  end

  assign cur_o = cur_q;

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_nxt_i |=> $stable(cur_q));

  // R3
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_nxt_i |=> (cur_q == src_e'($past(sel_i))));
endmodule

// File: rtl/bss_steer.sv
module bss_steer
  import bss_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                cur_i,
  input  logic [NUM_SRC-1:0]  valid_i,
  input  logic [NUM_SRC-1:0]  sop_i,
  input  logic [NUM_SRC-1:0]  eop_i,
  input  logic [DATA_W-1:0]   data_i [NUM_SRC],
  input  logic                drop_i,
  input  logic                out_ready_i,
  input  logic                out_xon_i,
  output logic                sel_valid_o,
  output logic                sel_sop_o,
  output logic                sel_eop_o,
  output logic [DATA_W-1:0]   sel_data_o,
  output logic [NUM_SRC-1:0]  ready_o,
  output logic [NUM_SRC-1:0]  xon_o
);
  always_comb begin
    sel_valid_o = valid_i[cur_i];
    sel_sop_o   = sop_i[cur_i];
    sel_eop_o   = eop_i[cur_i];
    sel_data_o  = data_i[cur_i];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic is_cur;
    assign is_cur     = (cur_i == 1'(g));
    assign ready_o[g] = is_cur & (drop_i | out_ready_i);
    assign xon_o[g]   = is_cur & out_xon_i;
  end
endmodule

// File: rtl/blk_stream_sel.sv
module blk_stream_sel
  import bss_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              usr_valid_i,
  input  logic              usr_sop_i,
  input  logic              usr_eop_i,
  input  logic [DATA_W-1:0] usr_data_i,
  output logic              usr_ready_o,
  output logic              usr_xon_o,
  input  logic              gen_valid_i,
  input  logic              gen_sop_i,
  input  logic              gen_eop_i,
  input  logic [DATA_W-1:0] gen_data_i,
  output logic              gen_ready_o,
  output logic              gen_xon_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  input  logic              out_xon_i
);
  localparam int unsigned IDX_USR = 0;
  localparam int unsigned IDX_GEN = 1;

  logic [NUM_SRC-1:0] v_a, s_a, e_a, rdy_a, xon_a;
  logic [DATA_W-1:0]  d_a [NUM_SRC];
  logic               sel_valid, sel_sop, sel_eop;
  logic               pass, open, open_nxt, drop;
  src_e               cur;

  assign v_a[IDX_USR] = usr_valid_i;
  assign s_a[IDX_USR] = usr_sop_i;
  assign e_a[IDX_USR] = usr_eop_i;
  assign d_a[IDX_USR] = usr_data_i;
  assign v_a[IDX_GEN] = gen_valid_i;
  assign s_a[IDX_GEN] = gen_sop_i;
  assign e_a[IDX_GEN] = gen_eop_i;
  assign d_a[IDX_GEN] = gen_data_i;

  assign usr_ready_o = rdy_a[IDX_USR];
  assign usr_xon_o   = xon_a[IDX_USR];
  assign gen_ready_o = rdy_a[IDX_GEN];
  assign gen_xon_o   = xon_a[IDX_GEN];

  // idle non-start beat on current source is flushed
  assign drop        = sel_valid & ~pass;
  assign out_valid_o = pass;
  assign out_sop_o   = sel_sop;
  assign out_eop_o   = sel_eop;

  bss_steer #(.DATA_W(DATA_W)) i_steer (
    .cur_i       (cur == SRC_GEN),
    .valid_i     (v_a),
    .sop_i       (s_a),
    .eop_i       (e_a),
    .data_i      (d_a),
    .drop_i      (drop),
    .out_ready_i (out_ready_i),
    .out_xon_i   (out_xon_i),
    .sel_valid_o (sel_valid),
    .sel_sop_o   (sel_sop),
    .sel_eop_o   (sel_eop),
    .sel_data_o  (out_data_o),
    .ready_o     (rdy_a),
    .xon_o       (xon_a)
  );

  bss_frame_track i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sel_valid),
    .sop_i      (sel_sop),
    .eop_i      (sel_eop),
    .ready_i    (out_ready_i),
    .pass_o     (pass),
    .open_o     (open),
    .open_nxt_o (open_nxt)
  );

  bss_src_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .open_nxt_i (open_nxt),
    .cur_o      (cur)
  );

  // R5
  unsel_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == SRC_USR) |-> (!gen_ready_o && !gen_xon_o));

  // R5
  unsel_usr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == SRC_GEN) |-> (!usr_ready_o && !usr_xon_o));

  // R6
  no_midframe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !open) |-> out_sop_o);

  // R2
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((cur == SRC_GEN) ? gen_valid_i : usr_valid_i));
endmodule

// File: tb/test_blk_stream_sel.sv
module test_blk_stream_sel;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0;
  logic uv = 0, us = 0, ue = 0, gv = 0, gs = 0, ge = 0, ordy = 1, oxon = 1;
  logic [DATA_W-1:0] ud = 8'h10, gd = 8'h80;
  logic usr_ready, usr_xon, gen_ready, gen_xon, o_v, o_s, o_e;
  logic [DATA_W-1:0] o_d;

  int unsigned n_chk = 0, n_err = 0;
  logic m_cur = 1'b0, m_open = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_stream_sel #(.DATA_W(DATA_W)) i_blk_stream_sel (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel),
    .usr_valid_i(uv), .usr_sop_i(us), .usr_eop_i(ue), .usr_data_i(ud),
    .usr_ready_o(usr_ready), .usr_xon_o(usr_xon),
    .gen_valid_i(gv), .gen_sop_i(gs), .gen_eop_i(ge), .gen_data_i(gd),
    .gen_ready_o(gen_ready), .gen_xon_o(gen_xon),
    .out_valid_o(o_v), .out_sop_o(o_s), .out_eop_o(o_e), .out_data_o(o_d),
    .out_ready_i(ordy), .out_xon_i(oxon)
  );

  // reference model of R1..R9
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur  <= 1'b0;
      m_open <= 1'b0;
    end else begin
      logic sv, ss, se, acc, nxt;
      sv  = m_cur ? gv : uv;
      ss  = m_cur ? gs : us;
      se  = m_cur ? ge : ue;
      acc = sv && (m_open || ss) && ordy;
      nxt = m_open;
      if (acc && se)      nxt = 1'b0;
      else if (acc && ss) nxt = 1'b1;
      m_open <= nxt;
      if (!nxt) m_cur <= sel;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic sv, ss, se, ps;
    logic [DATA_W-1:0] sd;
    sv = m_cur ? gv : uv;
    ss = m_cur ? gs : us;
    se = m_cur ? ge : ue;
    sd = m_cur ? gd : ud;
    ps = sv && (m_open || ss);
    chk(tag, 32'(o_v), 32'(ps), "out_valid");
    chk(tag, 32'(o_s), 32'(ss), "out_sop");
    chk(tag, 32'(o_e), 32'(se), "out_eop");
    chk(tag, 32'(o_d), 32'(sd), "out_data");
    chk(tag, 32'(m_cur ? gen_ready : usr_ready), 32'((sv && !ps) ? 1'b1 : ordy), "sel_ready");
    chk(tag, 32'(m_cur ? gen_xon : usr_xon), 32'(oxon), "sel_xon");
    chk("R5", 32'({m_cur ? usr_ready : gen_ready, m_cur ? usr_xon : gen_xon}), 32'(0), "unsel_ready_xon");
  endtask

  // u/g = {valid, sop, eop}
  task automatic drive(input logic s, input logic [2:0] u, input logic [2:0] g,
                       input logic r, input logic x, input string tag);
    @(negedge clk);
    sel = s; {uv, us, ue} = u; {gv, gs, ge} = g; ordy = r; oxon = x;
    ud = ud + 8'd1; gd = gd + 8'd3;
    #(CLK_PERIOD/4);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (2) @(negedge clk);
    // R1: select and generator traffic ignored while in reset
    drive(1, 3'b110, 3'b110, 1, 1, "R1");
    drive(1, 3'b100, 3'b110, 1, 0, "R1");
    @(negedge clk); sel = 1'b0; rst_n = 1'b1;
    drive(0, 3'b110, 3'b110, 1, 1, "R1");
    // R2: user packet passes through
    drive(0, 3'b100, 3'b000, 1, 1, "R2");
    drive(0, 3'b101, 3'b110, 1, 0, "R2");
    drive(0, 3'b000, 3'b110, 0, 1, "R2");
    // R6: idle non-start beats flushed
    drive(0, 3'b100, 3'b000, 0, 1, "R6");
    drive(0, 3'b101, 3'b000, 1, 1, "R6");
    // R3: idle switch lands one cycle later
    drive(1, 3'b110, 3'b000, 0, 1, "R3");
    drive(1, 3'b110, 3'b110, 1, 1, "R3");
    // R4: select drops mid-packet, switch after accepted eop
    drive(0, 3'b110, 3'b100, 1, 1, "R4");
    drive(0, 3'b110, 3'b100, 1, 1, "R4");
    drive(0, 3'b110, 3'b101, 1, 1, "R4");
    drive(0, 3'b110, 3'b110, 1, 1, "R4");
    // R8: eop held by ready low keeps packet open
    drive(0, 3'b101, 3'b000, 0, 1, "R8");
    drive(1, 3'b101, 3'b110, 0, 1, "R8");
    drive(1, 3'b101, 3'b110, 1, 1, "R8");
    drive(1, 3'b110, 3'b110, 1, 1, "R8");
    // R9: select pulse inside open generator packet
    drive(0, 3'b110, 3'b100, 1, 1, "R9");
    drive(1, 3'b110, 3'b100, 1, 1, "R9");
    drive(1, 3'b110, 3'b101, 1, 1, "R9");
    drive(1, 3'b110, 3'b110, 1, 1, "R9");
    drive(1, 3'b110, 3'b101, 1, 1, "R9");
    // R7: single-beat packet with select change in the same cycle
    drive(0, 3'b110, 3'b111, 1, 1, "R7");
    drive(0, 3'b111, 3'b111, 1, 1, "R7");
    drive(1, 3'b111, 3'b111, 1, 1, "R7");
    drive(1, 3'b000, 3'b111, 1, 1, "R7");
    // sweep
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive((lfsr[2:0] == 3'd0) ? ~sel : sel, lfsr[5:3], lfsr[8:6],
            lfsr[9] | lfsr[10], lfsr[11], "R2");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule